// File: doc/BRIEF.md
# Packed Rounding Shift and Narrowing Unit

This block is a purely combinational datapath for packed fixed-point work. It takes two 32-bit operands, a 5-bit shift amount, a 2-bit mode selector and a round enable, and produces a single 32-bit result in the same cycle. Nothing in the block holds state.

Three modes perform work:

- **Byte mode** treats operand A as four signed bytes and shifts each one right arithmetically.
- **Halfword mode** treats operand A as two unsigned halfwords and shifts each one right logically.
- **Narrowing mode** shifts both operands as signed 32-bit words and packs the low halves of the two results into one word.

Rounding applies only in byte mode and narrowing mode. When it is on, the last bit shifted out is added back into the lane. A shift of zero leaves every lane as it is.

The unit sits in an execute stage. Operand selection, decode and write-back belong to the surrounding pipeline.

Top module: `rsn_shift_narrow`

## Requirements
- R1: With mode_i = 0 (byte mode), each byte lane k of src_a_i (bits 8k+7..8k, signed) is shifted right arithmetically by s = shamt_i[2:0]. When round_i = 1 and s != 0, one is added if bit s-1 of the original lane is 1.
- R2: In byte mode each lane keeps only its own low 8 bits. A rounding carry wraps inside the lane, for example 0xFF shifted by 3 with rounding gives 0x00, and it never reaches the neighbouring lane.
- R3: A shift amount of zero for the active mode returns the lanes unchanged, whatever round_i is.
- R4: With mode_i = 1 (halfword mode), each 16-bit lane of src_a_i is shifted right logically by shamt_i[3:0] with zero fill. round_i has no effect in this mode.
- R5: With mode_i = 2 (narrowing mode), src_a_i and src_b_i are each shifted right arithmetically by shamt_i[4:0] and rounded as in R1. The low 16 bits of the src_a_i result go to result_o[31:16] and the low 16 bits of the src_b_i result go to result_o[15:0].
- R6: Shift bits above the width used by a mode are ignored: shamt_i[4:3] in byte mode and shamt_i[4] in halfword mode.
- R7: mode_i = 3 drives result_o to zero.
- R8: src_b_i has no effect on result_o in byte mode or in halfword mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_i | input | 32 | Packed lanes for byte and halfword modes; the upper word in narrowing mode |
| src_b_i | input | 32 | The lower word in narrowing mode; not used otherwise |
| shamt_i | input | 5 | Right-shift amount; each mode uses its low 3, 4 or 5 bits |
| mode_i | input | 2 | 0 byte arithmetic, 1 halfword logical, 2 narrowing, 3 idle |
| round_i | input | 1 | Adds the last bit shifted out in byte and narrowing modes |
| result_o | output | 32 | Shifted and packed result |

## Verification
The block holds no state, so any fault shows up on result_o in the same evaluation as the stimulus that exposes it. The faults most likely to be reached are these:

- a rounding bit taken from the wrong position;
- a carry that leaks across a lane boundary;
- a swapped narrowing half;
- a shift field that is too wide.

Each of these appears at once in a single vector with a known expected value. Directed vectors aim at lane edges and the extreme shift amounts. Seeded vectors, checked against a bench model built from the requirements, cover the rest of the operand space.

// File: rtl/rsn_pkg.sv
package rsn_pkg;
  localparam int WORD_W     = 32;
  localparam int SH_W       = 5;
  localparam int BYTE_W     = 8;
  localparam int HALF_W     = 16;
  localparam int BYTE_LANES = WORD_W / BYTE_W;
  localparam int HALF_LANES = WORD_W / HALF_W;
  localparam int BYTE_SH_W  = $clog2(BYTE_W);
  localparam int HALF_SH_W  = $clog2(HALF_W);

  typedef enum logic [1:0] {
    MODE_SHRA_B = 2'd0,
    MODE_SHRL_H = 2'd1,
    MODE_NARROW = 2'd2,
    MODE_IDLE   = 2'd3
  } rsn_mode_e;
endpackage

// File: rtl/rsn_round_lane.sv
// Arithmetic right shift of one signed lane with optional round-half-up.
// Only the low OUT_W bits of the rounded value are produced.
module rsn_round_lane #(
  parameter int IN_W  = 8,
  parameter int SH_W  = 3,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  lane_i,
  input  logic [SH_W-1:0]  sh_i,
  input  logic             rnd_i,
  output logic [OUT_W-1:0] lane_o
);
  localparam int IDX_W = $clog2(IN_W + 1);

  logic [IN_W:0]    ext;
  logic             rnd_bit;
  logic [OUT_W-1:0] shifted;

  // Index s of ext is bit s-1 of the lane. Index 0 is zero, so a zero shift never rounds.
  assign ext     = {lane_i, 1'b0};
  assign rnd_bit = rnd_i & ext[IDX_W'(sh_i)];
  assign shifted = OUT_W'($signed(lane_i) >>> sh_i);
  assign lane_o  = shifted + OUT_W'(rnd_bit);
endmodule

// File: rtl/rsn_byte_path.sv
module rsn_byte_path
  import rsn_pkg::*;
(
  input  logic [WORD_W-1:0]    src_i,
  input  logic [BYTE_SH_W-1:0] sh_i,
  input  logic                 rnd_i,
  output logic [WORD_W-1:0]    res_o
);
  for (genvar k = 0; k < BYTE_LANES; k++) begin : g_lane
    rsn_round_lane #(
      .IN_W (BYTE_W),
      .SH_W (BYTE_SH_W),
      .OUT_W(BYTE_W)
    ) u_lane (
      .lane_i(src_i[k*BYTE_W +: BYTE_W]),
      .sh_i  (sh_i),
      .rnd_i (rnd_i),
      .lane_o(res_o[k*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/rsn_half_path.sv
module rsn_half_path
  import rsn_pkg::*;
(
  input  logic [WORD_W-1:0]    src_i,
  input  logic [HALF_SH_W-1:0] sh_i,
  output logic [WORD_W-1:0]    res_o
);
  for (genvar k = 0; k < HALF_LANES; k++) begin : g_lane
    assign res_o[k*HALF_W +: HALF_W] = src_i[k*HALF_W +: HALF_W] >> sh_i;
  end
endmodule

// File: rtl/rsn_narrow_path.sv
module rsn_narrow_path
  import rsn_pkg::*;
(
  input  logic [WORD_W-1:0] hi_src_i,
  input  logic [WORD_W-1:0] lo_src_i,
  input  logic [SH_W-1:0]   sh_i,
  input  logic              rnd_i,
  output logic [WORD_W-1:0] res_o
);
  localparam int NARROW_W = WORD_W / 2;

  rsn_round_lane #(
    .IN_W (WORD_W),
    .SH_W (SH_W),
    .OUT_W(NARROW_W)
  ) u_hi (
    .lane_i(hi_src_i),
    .sh_i  (sh_i),
    .rnd_i (rnd_i),
    .lane_o(res_o[WORD_W-1:NARROW_W])
  );

  rsn_round_lane #(
    .IN_W (WORD_W),
    .SH_W (SH_W),
    .OUT_W(NARROW_W)
  ) u_lo (
    .lane_i(lo_src_i),
    .sh_i  (sh_i),
    .rnd_i (rnd_i),
    .lane_o(res_o[NARROW_W-1:0])
  );
endmodule

// File: rtl/rsn_shift_narrow.sv
module rsn_shift_narrow
  import rsn_pkg::*;
(
  input  logic [31:0] src_a_i,
  input  logic [31:0] src_b_i,
  input  logic [4:0]  shamt_i,
  input  logic [1:0]  mode_i,
  input  logic        round_i,
  output logic [31:0] result_o
);
  logic [WORD_W-1:0] byte_res;
  logic [WORD_W-1:0] half_res;
  logic [WORD_W-1:0] narrow_res;
  rsn_mode_e         mode;

  assign mode = rsn_mode_e'(mode_i);

  rsn_byte_path u_byte (
    .src_i(src_a_i),
    .sh_i (shamt_i[BYTE_SH_W-1:0]),
    .rnd_i(round_i),
    .res_o(byte_res)
  );

  rsn_half_path u_half (
    .src_i(src_a_i),
    .sh_i (shamt_i[HALF_SH_W-1:0]),
    .res_o(half_res)
  );

  rsn_narrow_path u_narrow (
    .hi_src_i(src_a_i),
    .lo_src_i(src_b_i),
    .sh_i    (shamt_i),
    .rnd_i   (round_i),
    .res_o   (narrow_res)
  );

  always_comb begin
    unique case (mode)
      MODE_SHRA_B: result_o = byte_res;
      MODE_SHRL_H: result_o = half_res;
      MODE_NARROW: result_o = narrow_res;
      default:     result_o = '0;
    endcase
  end
endmodule

// File: rtl/rsn_shift_narrow_chk.sv
module rsn_shift_narrow_chk (
  input logic [31:0] src_a_i,
  input logic [31:0] src_b_i,
  input logic [4:0]  shamt_i,
  input logic [1:0]  mode_i,
  input logic        round_i,
  input logic [31:0] result_o
);
  always_comb begin
    // R3: a zero byte shift returns operand A untouched
    if (mode_i == 2'd0 && shamt_i[2:0] == 3'd0)
      a_r3_byte_zero_shift: assert (result_o == src_a_i);
    // R5: a zero narrowing shift packs the two low halves
    if (mode_i == 2'd2 && shamt_i == 5'd0)
      a_r5_narrow_pack: assert (result_o == {src_a_i[15:0], src_b_i[15:0]});
    // R4: a nonzero logical shift clears the top bit of each halfword
    if (mode_i == 2'd1 && shamt_i[3:0] != 4'd0)
      a_r4_zero_fill: assert (result_o[31] == 1'b0 && result_o[15] == 1'b0);
    // R1: without rounding the arithmetic shift keeps each byte's sign
    if (mode_i == 2'd0 && !round_i)
      a_r1_sign_kept: assert (result_o[31] == src_a_i[31] && result_o[23] == src_a_i[23] &&
                              result_o[15] == src_a_i[15] && result_o[7] == src_a_i[7]);
    // R7: idle mode gives zero
    if (mode_i == 2'd3)
      a_r7_idle_zero: assert (result_o == 32'd0);
  end
endmodule

bind rsn_shift_narrow rsn_shift_narrow_chk u_chk (
  .src_a_i (src_a_i),
  .src_b_i (src_b_i),
  .shamt_i (shamt_i),
  .mode_i  (mode_i),
  .round_i (round_i),
  .result_o(result_o)
);

// File: tb/rsn_shift_narrow_tb.sv
`timescale 1ns/1ps
module rsn_shift_narrow_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_a, src_b, result;
  logic [4:0]  shamt;
  logic [1:0]  mode;
  logic        rnd;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  rsn_shift_narrow u_dut (
    .src_a_i (src_a),
    .src_b_i (src_b),
    .shamt_i (shamt),
    .mode_i  (mode),
    .round_i (rnd),
    .result_o(result)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [4:0] s,
                       input logic [1:0] m, input logic r);
    @(negedge clk);
    src_a = a; src_b = b; shamt = s; mode = m; rnd = r;
    #1;
  endtask

  // Reference: signed lane of width w, shifted by s, rounded by bit s-1.
  function automatic longint ref_round(input longint v, input int s, input bit r);
    longint q = v >>> s;
    if (r && s != 0 && ((v >> (s - 1)) & 1) != 0) q = q + 1;
    return q;
  endfunction

  function automatic logic [31:0] ref_model(input logic [31:0] a, input logic [31:0] b,
                                            input logic [4:0] s, input logic [1:0] m, input bit r);
    logic [31:0] o = '0;
    longint q;
    case (m)
      2'd0: for (int k = 0; k < 4; k++) begin
        q = ref_round(longint'($signed(a[8*k +: 8])), int'(s[2:0]), r);
        o[8*k +: 8] = q[7:0];
      end
      2'd1: for (int k = 0; k < 2; k++) o[16*k +: 16] = a[16*k +: 16] >> s[3:0];
      2'd2: begin
        q = ref_round(longint'($signed(a)), int'(s), r); o[31:16] = q[15:0];
        q = ref_round(longint'($signed(b)), int'(s), r); o[15:0]  = q[15:0];
      end
      default: o = '0;
    endcase
    return o;
  endfunction

  task automatic t_idle;
    apply(32'hDEAD_BEEF, 32'h1234_5678, 5'd7, 2'd3, 1'b1);
    check("R7 idle mode", result, 32'h0);
  endtask

  task automatic t_byte;
    apply(32'h807F_FF05, 32'h0, 5'd1, 2'd0, 1'b0);
    check("R1 byte shift 1 no round", result, 32'hC03F_FF02);
    apply(32'h807F_FF05, 32'h0, 5'd1, 2'd0, 1'b1);
    check("R1 byte shift 1 round", result, 32'hC040_0003);
    apply(32'hFF0C_F47F, 32'h0, 5'd3, 2'd0, 1'b1);
    check("R2 byte lane wrap shift 3", result, 32'h0002_FF10);
    apply(32'h0000_00FF, 32'h0, 5'd3, 2'd0, 1'b1);
    check("R2 carry stays in lane", result, 32'h0000_0000);
  endtask

  task automatic t_zero_shift;
    apply(32'h1234_5678, 32'h0, 5'b11000, 2'd0, 1'b1);
    check("R3 R6 byte zero low shift", result, 32'h1234_5678);
    apply(32'hF0F0_8181, 32'h0, 5'd0, 2'd1, 1'b1);
    check("R3 half zero shift", result, 32'hF0F0_8181);
    apply(32'hAAAA_1234, 32'h5555_ABCD, 5'd0, 2'd2, 1'b1);
    check("R3 R5 narrow zero shift", result, 32'h1234_ABCD);
  endtask

  task automatic t_half;
    apply(32'h8001_FFFF, 32'h0, 5'd4, 2'd1, 1'b1);
    check("R4 half logical round ignored", result, 32'h0800_0FFF);
    apply(32'h8001_FFFF, 32'h0, 5'd4, 2'd1, 1'b0);
    check("R4 half logical no round", result, 32'h0800_0FFF);
    apply(32'h8000_FFFF, 32'h0, 5'b10001, 2'd1, 1'b0);
    check("R6 half ignores shamt bit 4", result, 32'h4000_7FFF);
  endtask

  task automatic t_narrow;
    apply(32'h0001_8000, 32'hFFFF_7FFF, 5'd16, 2'd2, 1'b1);
    check("R5 narrow shift 16 round", result, 32'h0002_FFFF);
    apply(32'h0001_8000, 32'hFFFF_7FFF, 5'd16, 2'd2, 1'b0);
    check("R5 narrow shift 16 no round", result, 32'h0001_FFFF);
    apply(32'h4000_0000, 32'h8000_0000, 5'd31, 2'd2, 1'b1);
    check("R5 narrow shift 31 round", result, 32'h0001_FFFF);
  endtask

  task automatic t_b_ignored;
    logic [31:0] first;
    apply(32'h9C3A_7E11, 32'h0000_0000, 5'd2, 2'd0, 1'b1);
    first = result;
    apply(32'h9C3A_7E11, 32'hFFFF_FFFF, 5'd2, 2'd0, 1'b1);
    check("R8 byte ignores src_b", result, first);
    apply(32'h9C3A_7E11, 32'h0000_0000, 5'd5, 2'd1, 1'b0);
    first = result;
    apply(32'h9C3A_7E11, 32'hA5A5_5A5A, 5'd5, 2'd1, 1'b0);
    check("R8 half ignores src_b", result, first);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = $urandom;
      logic [4:0]  s = 5'($urandom);
      logic [1:0]  m = 2'($urandom % 3);
      logic        r = 1'($urandom);
      apply(a, b, s, m, r);
      check(m == 2'd0 ? "R1 sweep" : (m == 2'd1 ? "R4 sweep" : "R5 sweep"),
            result, ref_model(a, b, s, m, r));
    end
  endtask

  initial begin
    src_a = '0; src_b = '0; shamt = '0; mode = 2'd3; rnd = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    #1;
    check("R7 reset idle state", result, 32'h0);
    t_idle();
    t_byte();
    t_zero_shift();
    t_half();
    t_narrow();
    t_b_ignored();
    t_sweep();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule